// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects the interrupt requests of a small signal-processing core and turns them into one request with a 14-bit vector address. It has eleven sources. Six are external request pins, which are active low. The others are single-cycle event strobes from a timer, a byte DMA engine, two serial ports (one transmit and one receive strobe each) and a power-down controller. Software can also raise or drop any pending source. Each external pin runs either level-sensitive or edge-sensitive. Some pins are fixed to one type and some are programmable. The two pins for slots 8 and 9 share their vectors with the transmit and receive events of serial port 1, and a mode bit picks which of the two drives those vectors.

Pending requests are held until they are served. The maskable sources pass through a per-source mask and a global enable. The highest-priority eligible source wins. Its vector is presented with `irq_req` and held until the core returns `ack`, which clears the served source's pending state. Power-down is nonmaskable and sits directly below reset, even though its vector (0x2C) is numerically the highest.

Configuration uses a small write port. Address 0 is the mask, with bit i enabling slot i for slots 1..10. Address 1 is control: bit0 is the global enable, bit1 is edge mode for pin 0, bit2 is edge mode for pin 4, bit3 is edge mode for pin 5, and bit4 is shared-pin mode. Address 2 sets pending bits (write 1 to set). Address 3 clears pending bits (write 1 to clear).

Top module: `prio_vec_intc`

## Requirements
- R1: Among eligible sources the lowest slot number wins. The slots run 0 power-down, 1 pin 0, 2 pin 1, 3 pin 2, 4 serial port 0 transmit, 5 serial port 0 receive, 6 pin 3, 7 DMA, 8 pin 4 or serial port 1 transmit, 9 pin 5 or serial port 1 receive, 10 timer. Power-down therefore beats every maskable source.
- R2: The vector of slot s (1..10) is 4·s. The power-down vector is 0x2C.
- R3: While `irq_req` is high and `ack` is low, `irq_req` and `irq_vec` stay unchanged. When `ack` is sampled with `irq_req` high, `irq_req` is low in the next cycle.
- R4: An acknowledge clears the sticky pending state of the served source, so one event or one software set gives exactly one request.
- R5: A maskable slot is eligible only when its mask bit (address 0, bit = slot) and the global enable (address 1 bit0) are both 1. Power-down ignores both.
- R6: A level-sensitive pin (pins 1 and 2 always) is pending only while it is low. A pulse that ends while the source is not eligible leaves nothing behind.
- R7: Pin 3 is always edge-sensitive. A falling edge makes it pending until served, and holding the pin low gives only one request.
- R8: Control bits 1, 2 and 3 select edge (1) or level (0) operation for pins 0, 4 and 5.
- R9: With control bit4 = 0, slots 8 and 9 follow the serial port 1 transmit and receive strobes and pins 4 and 5 are ignored. With bit4 = 1, the pins drive those slots and the strobes are ignored.
- R10: A write to address 2 sets the pending bit of each slot whose data bit is 1. A write to address 3 clears those bits.
- R11: While `rst_n` is low, `irq_req` is 0 and `irq_vec` is 0x0000. Pending state, masks and control are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_req_n | input | 6 | External request pins, active low |
| pdn_evt | input | 1 | Power-down event strobe |
| sp0_tx_evt | input | 1 | Serial port 0 transmit strobe |
| sp0_rx_evt | input | 1 | Serial port 0 receive strobe |
| dma_evt | input | 1 | Byte DMA strobe |
| sp1_tx_evt | input | 1 | Serial port 1 transmit strobe |
| sp1_rx_evt | input | 1 | Serial port 1 receive strobe |
| tmr_evt | input | 1 | Timer strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 11 | Configuration write data |
| ack | input | 1 | Acknowledge from the core |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 14 | Vector address of the presented source |

## Verification
The assertions check the handshake on every cycle. Request and vector hold steady until acknowledge, and the request falls after it. They also check that the vector is always a legal word-aligned value and that the outputs are zero coming out of reset. Two more properties hold on every cycle: a pending power-down is presented as soon as the request line is free, and with the global enable off nothing else can raise a request. The bench scenarios are needed for the rest: the service order across several pending sources, level versus edge behaviour on the pins, the shared-pin mode switch, the software set and clear, and a source being served exactly once per event.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC   = 11;
  localparam int SLOT_W = $clog2(NSRC);
  localparam int VEC_W  = 14;
  localparam int NPIN   = 6;
  localparam int NCTL   = 5;

  // slot numbers, lower wins
  localparam int S_PDN = 0;
  localparam int S_XA  = 1;
  localparam int S_LB  = 2;
  localparam int S_LC  = 3;
  localparam int S_P0T = 4;
  localparam int S_P0R = 5;
  localparam int S_XE  = 6;
  localparam int S_DMA = 7;
  localparam int S_P1T = 8;
  localparam int S_P1R = 9;
  localparam int S_TMR = 10;

  localparam logic [1:0] CFG_MASK  = 2'd0;
  localparam logic [1:0] CFG_CTRL  = 2'd1;
  localparam logic [1:0] CFG_SWSET = 2'd2;
  localparam logic [1:0] CFG_SWCLR = 2'd3;

  localparam int C_GIE = 0;
  localparam int C_EA  = 1;
  localparam int C_ED  = 2;
  localparam int C_EF  = 3;
  localparam int C_PM  = 4;

  localparam logic [VEC_W-1:0] PDN_VEC = 14'h002C;

  function automatic logic [VEC_W-1:0] slot_vector(input logic [SLOT_W-1:0] s);
    if (s == SLOT_W'(S_PDN)) return PDN_VEC;
    return VEC_W'(s) << 2;
  endfunction

  function automatic logic [SLOT_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/intc_pin_front.sv
module intc_pin_front
  import intc_pkg::*;
#(
  parameter int W = NPIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_n,
  input  logic [W-1:0] edge_mode,
  output logic [W-1:0] hit
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= pin_n[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    // edge: falling seen after the synchronizer; level: synced low
    assign hit[g] = edge_mode[g] ? (s3 & ~s2) : ~s2;
  end
endmodule

// File: rtl/intc_pending.sv
module intc_pending
  import intc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  input  logic [N-1:0] level_in,
  output logic [N-1:0] pend
);
  logic [N-1:0] sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_in) | set_in;
  end

  assign pend = sticky_q | level_in;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   elig,
  input  logic              ack,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] win;
  logic              any_elig;

  assign win      = first_set(elig);
  assign any_elig = |elig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      vec_o  <= '0;
      slot_o <= '0;
    end else if (req_o) begin
      if (ack) req_o <= 1'b0;
    end else if (any_elig) begin
      req_o  <= 1'b1;
      slot_o <= win;
      vec_o  <= slot_vector(win);
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   ext_req_n,
  input  logic              pdn_evt,
  input  logic              sp0_tx_evt,
  input  logic              sp0_rx_evt,
  input  logic              dma_evt,
  input  logic              sp1_tx_evt,
  input  logic              sp1_rx_evt,
  input  logic              tmr_evt,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [NSRC-1:0]   cfg_wdata,
  input  logic              ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [NSRC-1:1]   mask_q;
  logic [NCTL-1:0]   ctrl_q;
  logic              gie_q;
  logic              pin_mode;
  logic [NPIN-1:0]   edge_mode;
  logic [NPIN-1:0]   pin_hit;
  logic [NSRC-1:0]   sw_set, sw_clr, ack_clr;
  logic [NSRC-1:0]   set_all, lvl_all, pend_all, elig_all;
  logic [SLOT_W-1:0] svc_slot;
  logic              svc_done;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_MASK) mask_q <= cfg_wdata[NSRC-1:1];
      if (cfg_addr == CFG_CTRL) ctrl_q <= cfg_wdata[NCTL-1:0];
    end
  end

  assign gie_q    = ctrl_q[C_GIE];
  assign pin_mode = ctrl_q[C_PM];
  assign sw_set   = (cfg_we && cfg_addr == CFG_SWSET) ? cfg_wdata : '0;
  assign sw_clr   = (cfg_we && cfg_addr == CFG_SWCLR) ? cfg_wdata : '0;

  // pin order: 0 prog, 1 level, 2 level, 3 edge, 4 prog shared, 5 prog shared
  assign edge_mode = {ctrl_q[C_EF], ctrl_q[C_ED], 1'b1, 1'b0, 1'b0, ctrl_q[C_EA]};

  intc_pin_front #(.W(NPIN)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (ext_req_n),
    .edge_mode(edge_mode),
    .hit      (pin_hit)
  );

  always_comb begin
    set_all = '0;
    lvl_all = '0;
    set_all[S_PDN] = pdn_evt;
    set_all[S_XA]  = pin_hit[0] & ctrl_q[C_EA];
    lvl_all[S_XA]  = pin_hit[0] & ~ctrl_q[C_EA];
    lvl_all[S_LB]  = pin_hit[1];
    lvl_all[S_LC]  = pin_hit[2];
    set_all[S_P0T] = sp0_tx_evt;
    set_all[S_P0R] = sp0_rx_evt;
    set_all[S_XE]  = pin_hit[3];
    set_all[S_DMA] = dma_evt;
    set_all[S_P1T] = pin_mode ? (pin_hit[4] & ctrl_q[C_ED]) : sp1_tx_evt;
    lvl_all[S_P1T] = pin_mode & pin_hit[4] & ~ctrl_q[C_ED];
    set_all[S_P1R] = pin_mode ? (pin_hit[5] & ctrl_q[C_EF]) : sp1_rx_evt;
    lvl_all[S_P1R] = pin_mode & pin_hit[5] & ~ctrl_q[C_EF];
    set_all[S_TMR] = tmr_evt;
    set_all = set_all | sw_set;
  end

  assign svc_done = irq_req & ack;
  assign ack_clr  = svc_done ? (NSRC'(1) << svc_slot) : '0;

  intc_pending #(.N(NSRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_in  (set_all),
    .clr_in  (ack_clr | sw_clr),
    .level_in(lvl_all),
    .pend    (pend_all)
  );

  // power-down bypasses mask and global enable
  assign elig_all[S_PDN]    = pend_all[S_PDN];
  assign elig_all[NSRC-1:1] = pend_all[NSRC-1:1] & mask_q & {(NSRC-1){gie_q}};

  intc_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig_all),
    .ack   (ack),
    .req_o (irq_req),
    .vec_o (irq_vec),
    .slot_o(svc_slot)
  );
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk
  import intc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [NSRC-1:0]  pend_w,
  input logic             gie_w
);
  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack |=> irq_req && $stable(irq_vec));

  assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && ack |=> !irq_req);

  assert_legal_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec[1:0] == 2'b00 && irq_vec != '0 && irq_vec <= PDN_VEC);

  assert_pdn_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && pend_w[S_PDN] |=> irq_req && irq_vec == PDN_VEC);

  assert_gie_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && !gie_w && !pend_w[S_PDN] |=> !irq_req);

  assert_reset_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_req && irq_vec == '0);
endmodule

bind prio_vec_intc prio_vec_intc_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ack    (ack),
  .irq_req(irq_req),
  .irq_vec(irq_vec),
  .pend_w (pend_all),
  .gie_w  (gie_q)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  ext_req_n;
  logic        pdn_evt, sp0_tx_evt, sp0_rx_evt, dma_evt, sp1_tx_evt, sp1_rx_evt, tmr_evt;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [10:0] cfg_wdata;
  logic        ack;
  logic        irq_req;
  logic [13:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];
  bit          mon_en = 1'b0;
  bit          busy = 1'b0;
  int          hold_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n),
    .pdn_evt(pdn_evt), .sp0_tx_evt(sp0_tx_evt), .sp0_rx_evt(sp0_rx_evt),
    .dma_evt(dma_evt), .sp1_tx_evt(sp1_tx_evt), .sp1_rx_evt(sp1_rx_evt),
    .tmr_evt(tmr_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ack(ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // vector expected for a slot, restated from the requirement
  function automatic logic [13:0] vec_of(input int slot);
    return (slot == 0) ? 14'd44 : 14'(slot * 4);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic expect_slot(input int slot, input string rq);
    exp_q.push_back(vec_of(slot));
    tag_q.push_back(rq);
  endtask

  task automatic cfg(input logic [1:0] a, input logic [10:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string rq);
    int t = 0;
    while ((exp_q.size() != 0 || busy) && t < 80) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0 && !busy, rq, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic quiet(input int n, input string rq);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (irq_req) seen = 1'b1;
    end
    chk(!seen, rq, seen, 0);
  endtask

  task automatic manual_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // monitor: pops expected vectors and acknowledges
  initial begin
    ack = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en && irq_req && exp_q.size() > 0) begin
        logic [13:0] e;
        string t;
        bit stable_ok;
        busy = 1'b1;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(irq_vec == e, t, irq_vec, e);
        if (hold_n > 0) begin
          stable_ok = 1'b1;
          repeat (hold_n) begin
            @(negedge clk);
            if (!irq_req || irq_vec != e) stable_ok = 1'b0;
          end
          chk(stable_ok, "R3 hold", irq_vec, e);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(!irq_req, "R3 drop", irq_req, 0);
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; ext_req_n = '1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pdn_evt = 0; sp0_tx_evt = 0; sp0_rx_evt = 0; dma_evt = 0;
    sp1_tx_evt = 0; sp1_rx_evt = 0; tmr_evt = 0;
    cycles(3);
    chk(!irq_req && irq_vec == 0, "R11 reset", {irq_req, irq_vec}, 0);
    rst_n = 1'b1;
    cycles(2);
    chk(!irq_req && irq_vec == 0, "R11 after reset", {irq_req, irq_vec}, 0);
    mon_en = 1'b1;

    // R5: power-down with masks and enable off
    expect_slot(0, "R5 pdn bypass");
    @(negedge clk); pdn_evt = 1; @(negedge clk); pdn_evt = 0;
    drain("R5 pdn served");

    // R1/R2: priority order of several pendings
    cfg(2'd0, 11'h7FE);
    cfg(2'd2, 11'b100_1001_0010);
    quiet(8, "R5 gie off blocks");
    hold_n = 2;
    expect_slot(1, "R1 R2 slot1");
    expect_slot(4, "R1 R2 slot4");
    expect_slot(7, "R1 R2 slot7");
    expect_slot(10, "R1 R2 slot10");
    cfg(2'd1, 11'h001);
    drain("R1 order");
    hold_n = 0;

    // R1: power-down ahead of slot 1 set together
    expect_slot(0, "R1 pdn top");
    expect_slot(1, "R1 after pdn");
    cfg(2'd2, 11'h003);
    drain("R1 pdn first");

    // R5: individual mask
    cfg(2'd0, 11'h7DE);
    cfg(2'd2, 11'h020);
    quiet(8, "R5 mask off");
    expect_slot(5, "R5 unmasked");
    cfg(2'd0, 11'h7FE);
    drain("R5 mask on");

    // R10: software set then clear
    cfg(2'd1, 11'h000);
    cfg(2'd2, 11'h080);
    cfg(2'd3, 11'h080);
    cfg(2'd1, 11'h001);
    quiet(8, "R10 cleared");
    expect_slot(3, "R10 sw set");
    cfg(2'd2, 11'h008);
    drain("R10 set served");

    // R7: fixed edge pin held low gives one request
    expect_slot(6, "R7 edge");
    @(negedge clk); ext_req_n[3] = 1'b0;
    drain("R7 edge served");
    quiet(10, "R7 no repeat");
    ext_req_n[3] = 1'b1;
    quiet(4, "R7 rise quiet");

    // R8: programmable pin in edge mode
    cfg(2'd1, 11'h003);
    expect_slot(1, "R8 edge mode");
    @(negedge clk); ext_req_n[0] = 1'b0;
    drain("R8 edge served");
    quiet(8, "R8 edge once");
    ext_req_n[0] = 1'b1;
    cycles(4);

    // R8: programmable pin in level mode, checked by hand
    mon_en = 1'b0;
    cfg(2'd1, 11'h001);
    ext_req_n[0] = 1'b0;
    cycles(6);
    chk(irq_req && irq_vec == vec_of(1), "R8 level req", irq_vec, vec_of(1));
    manual_ack();
    chk(!irq_req, "R3 manual drop", irq_req, 0);
    cycles(4);
    chk(irq_req && irq_vec == vec_of(1), "R8 level repeats", irq_vec, vec_of(1));
    ext_req_n[0] = 1'b1;
    cycles(4);
    chk(irq_req && irq_vec == vec_of(1), "R3 held after release", irq_vec, vec_of(1));
    manual_ack();
    quiet(6, "R8 level gone");
    mon_en = 1'b1;

    // R6: fixed level pulse while disabled leaves nothing
    cfg(2'd1, 11'h000);
    ext_req_n[1] = 1'b0;
    cycles(6);
    ext_req_n[1] = 1'b1;
    cycles(6);
    cfg(2'd1, 11'h001);
    quiet(8, "R6 level not latched");

    // R9: serial mode ignores pin 4, follows strobe
    ext_req_n[4] = 1'b0;
    quiet(8, "R9 pin ignored");
    ext_req_n[4] = 1'b1;
    cycles(4);
    expect_slot(8, "R9 strobe tx");
    @(negedge clk); sp1_tx_evt = 1; @(negedge clk); sp1_tx_evt = 0;
    drain("R9 strobe served");

    // R9: pin mode, edge on pin 5, strobe ignored
    cfg(2'd1, 11'h01D);
    expect_slot(9, "R9 pin rx");
    @(negedge clk); ext_req_n[5] = 1'b0;
    drain("R9 pin served");
    ext_req_n[5] = 1'b1;
    cycles(4);
    @(negedge clk); sp1_rx_evt = 1; @(negedge clk); sp1_rx_evt = 0;
    quiet(8, "R9 strobe ignored");

    // R4: one strobe gives one service
    expect_slot(10, "R4 timer");
    @(negedge clk); tmr_evt = 1; @(negedge clk); tmr_evt = 0;
    drain("R4 served");
    quiet(8, "R4 cleared by ack");

    // R11: reset mid-run clears pending, masks and control
    cfg(2'd1, 11'h000);
    cfg(2'd2, 11'h410);
    @(negedge clk); rst_n = 1'b0;
    cycles(2);
    chk(!irq_req && irq_vec == 0, "R11 mid reset", {irq_req, irq_vec}, 0);
    rst_n = 1'b1;
    cfg(2'd1, 11'h001);
    quiet(6, "R11 mask cleared");
    cfg(2'd0, 11'h7FE);
    quiet(8, "R11 pending cleared");

    report();
  end
endmodule